// File: doc/BRIEF.md
# Raised-Cosine Soft Mute Ramp

This block sits in the digital audio path ahead of the interpolation stage. It multiplies each stereo pair of 24-bit signed samples by a gain that moves smoothly between unity and zero. When a mute is requested, the gain follows a raised-cosine curve down to silence. When the request is withdrawn, the gain climbs back up the same curve. Because the gain has no sudden steps, muting and unmuting make no audible click.

The mute request has two sources: a static pin and a bit from a control register. A mode input chooses which source applies, and the other source is ignored. The block leaves reset fully muted, so in register-control mode nothing is heard until the register bit is cleared. The ramp advances only on sample strobes, so its length is counted in samples and does not depend on the clock rate. A done flag shows when the gain is settled at one of its two end points.

Top module: `soft_mute_ramp`

## Requirements
- R1: While reset is applied and until the first sample after it, `out_valid` is 0, `ramp_done` is 1 and the step index is at its muted end (gain 0), whatever the mode.
- R2: For each cycle with `in_valid` high, `out_valid` is high exactly one clock later. In that cycle each channel holds `floor((x*g + 2^14) / 2^15)`, saturated to the signed 24-bit range, where x is the input sample and g is the gain in force when the sample arrived.
- R3: The gain at step index s (0 to 32) is `trunc(32768*(1+cos(pi*s/32))/2 + 0.5)`. Index 0 is unity (32768) and index 32 is zero.
- R4: While mute is requested and the index is below 32, the index rises by one after every 32 accepted samples. A full mute therefore spans 32×32 = 1024 samples, and the index never changes on a cycle without `in_valid`.
- R5: While mute is not requested and the index is above 0, the index falls by one after every 32 accepted samples. Unmute thus walks the same gain table in reverse order.
- R6: If the request changes in the middle of a ramp, the index turns around from its current value and never jumps. The count of samples already spent at the current step carries on. A sample that arrives while the index is at the target end clears that count.
- R7: With `ctl_mode` = 0 (static mode), the request is `mute_pin`, and `mute_reg` has no effect on the output.
- R8: With `ctl_mode` = 1 (register mode), the request is `mute_reg`, and `mute_pin` has no effect on the output.
- R9: `ramp_done` is 1 exactly when the step index sits at 0 or 32. It is updated on the same edge as the output sample.
- R10: After reset in register mode with `mute_reg` = 1, every output sample is zero until `mute_reg` is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Sample strobe for the stereo pair |
| in_left | input | 24 | Left sample, signed |
| in_right | input | 24 | Right sample, signed |
| ctl_mode | input | 1 | Mute source select: 0 = pin, 1 = register bit |
| mute_pin | input | 1 | Static-mode mute request |
| mute_reg | input | 1 | Register-mode mute request |
| out_valid | output | 1 | Scaled sample strobe |
| out_left | output | 24 | Scaled left sample, signed |
| out_right | output | 24 | Scaled right sample, signed |
| ramp_done | output | 1 | Gain settled at zero or at unity |

## Verification
The bench uses the default parameters: 32 gain steps, each held for 32 samples, with a 15-bit gain fraction. These values put every entry of the cosine table within reach, along with full 1024-sample ramps in both directions and a reversal partway through a ramp. Full-scale positive and most-negative samples pass through at unity gain and at intermediate gains, which tests the rounding and the saturation bounds. Sample strobes arrive with irregular gaps, which shows that the ramp counts samples and not clocks.

// File: rtl/soft_mute_pkg.sv
package soft_mute_pkg;

  typedef enum logic {
    SRC_PIN = 1'b0,
    SRC_REG = 1'b1
  } mute_src_e;

  localparam real SM_PI = 3.14159265358979323846;

endpackage

// File: rtl/sm_reset_sync.sv
module sm_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/sm_gain_lut.sv
module sm_gain_lut #(
  parameter int STEPS_LOG2 = 5,
  parameter int FRAC_W     = 15,
  localparam int STEPS     = 1 << STEPS_LOG2,
  localparam int IDX_W     = STEPS_LOG2 + 1,
  localparam int GAIN_W    = FRAC_W + 1
) (
  input  logic [IDX_W-1:0]  idx,
  output logic [GAIN_W-1:0] gain
);

  // One level of the raised-cosine curve, evaluated at elaboration.
  function automatic logic [GAIN_W-1:0] level_at(input int s);
    real c;
    real v;
    c = $cos(soft_mute_pkg::SM_PI * real'(s) / real'(STEPS));
    v = 0.5 * real'(1 << FRAC_W) * (1.0 + c) + 0.5;
    return GAIN_W'($rtoi(v));
  endfunction

  logic [GAIN_W-1:0] lvl [STEPS+1];

  generate
    for (genvar i = 0; i <= STEPS; i++) begin : g_lvl
      localparam logic [GAIN_W-1:0] LV = level_at(i);
      assign lvl[i] = LV;
    end
  endgenerate

  always_comb begin
    if (int'(idx) <= STEPS) begin
      gain = lvl[idx];
    end else begin
      gain = '0;
    end
  end

endmodule

// File: rtl/sm_ramp_ctrl.sv
module sm_ramp_ctrl #(
  parameter int STEPS_LOG2 = 5,
  parameter int HOLD_LOG2  = 5,
  localparam int STEPS     = 1 << STEPS_LOG2,
  localparam int IDX_W     = STEPS_LOG2 + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_valid,
  input  logic             req_mute,
  output logic [IDX_W-1:0] idx,
  output logic             settled
);

  localparam logic [IDX_W-1:0]     IDX_MUTED = IDX_W'(STEPS);
  localparam logic [HOLD_LOG2-1:0] HOLD_MAX  = '1;

  logic [IDX_W-1:0]     idx_q, idx_d;
  logic [HOLD_LOG2-1:0] hold_q, hold_d;
  logic                 at_target;

  assign at_target = req_mute ? (idx_q == IDX_MUTED) : (idx_q == '0);

  always_comb begin
    idx_d  = idx_q;
    hold_d = hold_q;
    if (smp_valid) begin
      if (at_target) begin
        hold_d = '0;
      end else if (hold_q == HOLD_MAX) begin
        hold_d = '0;
        if (req_mute) begin
          idx_d = idx_q + 1'b1;
        end else begin
          idx_d = idx_q - 1'b1;
        end
      end else begin
        hold_d = hold_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= IDX_MUTED;
      hold_q <= '0;
    end else if (smp_valid) begin
      idx_q  <= idx_d;
      hold_q <= hold_d;
    end
  end

  assign idx     = idx_q;
  assign settled = (idx_q == '0) || (idx_q == IDX_MUTED);

endmodule

// File: rtl/sm_scaler.sv
module sm_scaler #(
  parameter int DATA_W   = 24,
  parameter int FRAC_W   = 15,
  localparam int GAIN_W  = FRAC_W + 1,
  localparam int PROD_W  = DATA_W + GAIN_W + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic signed [DATA_W-1:0] sample,
  input  logic [GAIN_W-1:0]        gain,
  output logic signed [DATA_W-1:0] result
);

  localparam logic signed [PROD_W-1:0] MAXV = (PROD_W'(1) <<< (DATA_W - 1)) - PROD_W'(1);
  localparam logic signed [PROD_W-1:0] MINV = -(PROD_W'(1) <<< (DATA_W - 1));
  localparam logic signed [PROD_W-1:0] HALF = PROD_W'(1) <<< (FRAC_W - 1);

  logic signed [PROD_W-1:0] a_ext, b_ext, prod, rnd, shr;
  logic signed [DATA_W-1:0] sat_d, result_q;

  always_comb begin
    a_ext = PROD_W'(sample);
    b_ext = $signed(PROD_W'({1'b0, gain}));
    prod  = a_ext * b_ext;
    rnd   = prod + HALF;
    shr   = rnd >>> FRAC_W;
    if (shr > MAXV) begin
      sat_d = MAXV[DATA_W-1:0];
    end else if (shr < MINV) begin
      sat_d = MINV[DATA_W-1:0];
    end else begin
      sat_d = shr[DATA_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
    end else if (en) begin
      result_q <= sat_d;
    end
  end

  assign result = result_q;

endmodule

// File: rtl/soft_mute_ramp.sv
module soft_mute_ramp #(
  parameter int DATA_W     = 24,
  parameter int FRAC_W     = 15,
  parameter int STEPS_LOG2 = 5,
  parameter int HOLD_LOG2  = 5,
  localparam int IDX_W     = STEPS_LOG2 + 1,
  localparam int GAIN_W    = FRAC_W + 1,
  localparam int NCH       = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_left,
  input  logic [DATA_W-1:0] in_right,
  input  logic              ctl_mode,
  input  logic              mute_pin,
  input  logic              mute_reg,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_left,
  output logic [DATA_W-1:0] out_right,
  output logic              ramp_done
);

  import soft_mute_pkg::*;

  logic              rst_sync_n;
  logic              req_mute;
  logic [IDX_W-1:0]  step_idx;
  logic [GAIN_W-1:0] cur_gain;
  logic              out_valid_q;
  mute_src_e         src;

  logic signed [DATA_W-1:0] ch_in  [NCH];
  logic signed [DATA_W-1:0] ch_out [NCH];

  sm_reset_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign src = mute_src_e'(ctl_mode);

  always_comb begin
    unique case (src)
      SRC_REG: req_mute = mute_reg;
      default: req_mute = mute_pin;
    endcase
  end

  sm_ramp_ctrl #(
    .STEPS_LOG2 (STEPS_LOG2),
    .HOLD_LOG2  (HOLD_LOG2)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .smp_valid (in_valid),
    .req_mute  (req_mute),
    .idx       (step_idx),
    .settled   (ramp_done)
  );

  sm_gain_lut #(
    .STEPS_LOG2 (STEPS_LOG2),
    .FRAC_W     (FRAC_W)
  ) u_lut (
    .idx  (step_idx),
    .gain (cur_gain)
  );

  assign ch_in[0] = $signed(in_left);
  assign ch_in[1] = $signed(in_right);

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      sm_scaler #(
        .DATA_W (DATA_W),
        .FRAC_W (FRAC_W)
      ) u_scl (
        .clk    (clk),
        .rst_n  (rst_sync_n),
        .en     (in_valid),
        .sample (ch_in[c]),
        .gain   (cur_gain),
        .result (ch_out[c])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_valid_q <= 1'b0;
    end else begin
      out_valid_q <= in_valid;
    end
  end

  assign out_valid = out_valid_q;
  assign out_left  = ch_out[0];
  assign out_right = ch_out[1];

endmodule

// File: rtl/sm_checker.sv
module sm_checker #(
  parameter int DATA_W     = 24,
  parameter int FRAC_W     = 15,
  parameter int STEPS_LOG2 = 5,
  localparam int IDX_W     = STEPS_LOG2 + 1,
  localparam int GAIN_W    = FRAC_W + 1
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              in_valid,
  input logic              ctl_mode,
  input logic              mute_reg,
  input logic              mute_pin,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_left,
  input logic [DATA_W-1:0] out_right,
  input logic              ramp_done,
  input logic [IDX_W-1:0]  step_idx,
  input logic [GAIN_W-1:0] cur_gain
);

  localparam logic [GAIN_W-1:0] UNITY = GAIN_W'(1) << FRAC_W;

  // R2: output strobe trails the input strobe by one clock
  p_out_lag_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_valid == $past(in_valid));

  // R4: the step index moves only on accepted samples
  p_idx_on_valid_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !$past(in_valid) |-> $stable(step_idx));

  // R6: a change of index is a single step in either direction
  p_no_jump_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (step_idx != $past(step_idx)) |->
      ((step_idx == $past(step_idx) + 1'b1) || (step_idx + 1'b1 == $past(step_idx))));

  // R9: settled flag agrees with the gain produced by the table
  p_done_ends_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ramp_done |-> ((cur_gain == '0) || (cur_gain == UNITY)));

  // R10: a zero gain gives zero samples
  p_zero_out_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid && ($past(cur_gain) == '0)) |-> ((out_left == '0) && (out_right == '0)));

  // R8: a mute request from the register never lets the index fall
  p_reg_hold_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(ctl_mode) && $past(mute_reg) && $past(in_valid)) |-> (step_idx >= $past(step_idx)));

  // R7: a mute request from the pin never lets the index fall
  p_pin_hold_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!$past(ctl_mode) && $past(mute_pin) && $past(in_valid)) |-> (step_idx >= $past(step_idx)));

endmodule

bind soft_mute_ramp sm_checker #(
  .DATA_W     (DATA_W),
  .FRAC_W     (FRAC_W),
  .STEPS_LOG2 (STEPS_LOG2)
) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .in_valid   (in_valid),
  .ctl_mode   (ctl_mode),
  .mute_reg   (mute_reg),
  .mute_pin   (mute_pin),
  .out_valid  (out_valid),
  .out_left   (out_left),
  .out_right  (out_right),
  .ramp_done  (ramp_done),
  .step_idx   (step_idx),
  .cur_gain   (cur_gain)
);

// File: tb/tb_soft_mute_ramp.sv
module tb_soft_mute_ramp;

  localparam int  STEPS = 32;
  localparam int  HOLD  = 32;
  localparam int  FRAC  = 15;
  localparam real PI_V  = 3.14159265358979323846;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [23:0] in_left, in_right;
  logic        ctl_mode, mute_pin, mute_reg;
  logic        out_valid;
  logic [23:0] out_left, out_right;
  logic        ramp_done;

  soft_mute_ramp dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_left   (in_left),
    .in_right  (in_right),
    .ctl_mode  (ctl_mode),
    .mute_pin  (mute_pin),
    .mute_reg  (mute_reg),
    .out_valid (out_valid),
    .out_left  (out_left),
    .out_right (out_right),
    .ramp_done (ramp_done)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct {
    logic [23:0] l;
    logic [23:0] r;
    logic        done;
    string       tag;
  } item_t;

  item_t exp_q[$];
  int    checks = 0;
  int    fails  = 0;
  int    m_idx  = STEPS;
  int    m_hold = 0;
  int    n_sent = 0;
  int    cycles = 0;
  bit    finished = 0;
  logic [31:0] lfsr = 32'h1ACE_B00C;

  // Gain table from R3
  function automatic longint gain_of(input int s);
    real c;
    c = $cos(PI_V * real'(s) / real'(STEPS));
    return longint'($rtoi(real'(1 << FRAC) * (1.0 + c) / 2.0 + 0.5));
  endfunction

  // Rounding and saturation from R2
  function automatic logic [23:0] scale(input logic [23:0] x, input longint g);
    longint p;
    p = longint'($signed(x)) * g;
    p = (p + (longint'(1) <<< (FRAC - 1))) >>> FRAC;
    if (p > 8388607) p = 8388607;
    if (p < -8388608) p = -8388608;
    return p[23:0];
  endfunction

  function automatic logic [23:0] next_pattern(input int n);
    if (n % 13 == 0) return 24'h7FFFFF;
    if (n % 17 == 0) return 24'h800000;
    lfsr = lfsr ^ (lfsr << 13);
    lfsr = lfsr ^ (lfsr >> 17);
    lfsr = lfsr ^ (lfsr << 5);
    return lfsr[23:0];
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  // Driver: computes the expected item and queues it, then applies the sample
  task automatic send(input string tag);
    item_t it;
    logic [23:0] l, r;
    bit req;
    bit at_t;
    longint g;
    l = next_pattern(n_sent);
    r = next_pattern(n_sent + 7);
    n_sent++;
    req = ctl_mode ? mute_reg : mute_pin;
    g = gain_of(m_idx);
    it.l = scale(l, g);
    it.r = scale(r, g);
    at_t = req ? (m_idx == STEPS) : (m_idx == 0);
    if (at_t) begin
      m_hold = 0;
    end else if (m_hold == HOLD - 1) begin
      m_hold = 0;
      m_idx = req ? m_idx + 1 : m_idx - 1;
    end else begin
      m_hold++;
    end
    it.done = (m_idx == 0) || (m_idx == STEPS);
    it.tag = tag;
    exp_q.push_back(it);
    @(negedge clk);
    in_valid = 1'b1;
    in_left  = l;
    in_right = r;
    @(negedge clk);
    in_valid = 1'b0;
    for (int k = 0; k < (n_sent % 3); k++) @(negedge clk);
  endtask

  task automatic send_n(input int n, input string tag);
    for (int i = 0; i < n; i++) send(tag);
  endtask

  // Monitor: pops the expected item whenever a result appears
  always @(negedge clk) begin
    if (out_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2", "unexpected out_valid", 1, 0);
      end else begin
        item_t e;
        e = exp_q.pop_front();
        check(out_left == e.l, e.tag, "left (R2/R3)",
              longint'($signed(out_left)), longint'($signed(e.l)));
        check(out_right == e.r, e.tag, "right (R2/R3)",
              longint'($signed(out_right)), longint'($signed(e.r)));
        check(ramp_done == e.done, e.tag, "ramp_done (R9)",
              longint'(ramp_done), longint'(e.done));
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      finish_run();
    end
  end

  initial begin
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_left  = '0;
    in_right = '0;
    ctl_mode = 1'b1;
    mute_pin = 1'b0;
    mute_reg = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(out_valid == 1'b0, "R1", "out_valid in reset", longint'(out_valid), 0);
    check(ramp_done == 1'b1, "R1", "ramp_done in reset", longint'(ramp_done), 1);
    check(out_left == '0, "R1", "out_left in reset", longint'(out_left), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid after release", longint'(out_valid), 0);
    check(ramp_done == 1'b1, "R1", "ramp_done after release", longint'(ramp_done), 1);

    // R10: register mode starts muted and stays so while the bit is set
    send_n(80, "R10");

    // R8: register bit cleared, pin raised; pin ignored, ramp up (R5)
    mute_reg = 1'b0;
    mute_pin = 1'b1;
    send_n(1100, "R5");
    for (int i = 0; i < 40; i++) begin
      mute_pin = ~mute_pin;
      send("R8");
    end

    // R7: static mode, register bit set but ignored
    ctl_mode = 1'b0;
    mute_pin = 1'b0;
    mute_reg = 1'b1;
    send_n(40, "R7");

    // R4: full mute ramp from the pin
    mute_pin = 1'b1;
    send_n(1100, "R4");

    // R6: reversals partway through ramps
    mute_pin = 1'b0;
    send_n(300, "R6");
    mute_pin = 1'b1;
    send_n(205, "R6");
    mute_pin = 1'b0;
    send_n(1100, "R6");

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R2", "results outstanding", longint'(exp_q.size()), 0);
    finish_run();
  end

endmodule